// File: doc/BRIEF.md
# SDRAM Mode Command and Low-Power Sequencer

This block sends mode-setting commands, requested by software, to one or two SDRAM devices, and it manages the low-power states of those devices. Each request carries a three-bit mode code and a target mask with one bit per device. A command can go to device 0, to device 1, or to both in the same cycle. The block drives a chip select and a clock enable for each device, plus the shared row strobe, column strobe and write-enable lines.

Each device has its own state: awake, self-refresh or power-down. Self-refresh ends in one of two ways: a normal-mode command, or an access request aimed at that device. Power-down ends only on a normal-mode command. A device in power-down does not refresh itself, so a built-in timer makes the block raise that device's clock enable, send an auto-refresh, and lower the clock enable again.

Top module: `sdr_mode_ctrl`

## Requirements
- R1: After reset, both clock enables are low, both chip selects are high, the row strobe, column strobe and write enable are high (NOP), and busy is low.
- R2: A command is accepted on a clock edge where cmd_valid is high and busy is low. For mode 2 (precharge all), mode 3 (auto-refresh) and mode 4 (load mode register), the cycle after acceptance shows the command for exactly one cycle. The encoding on (ras_n, cas_n, we_n) is L,H,L for precharge, L,L,H for auto-refresh and L,L,L for load mode. In that cycle sd_cs_n[i] is low exactly for the devices whose cmd_target[i] bit is 1.
- R3: Mode 1 (clock-enable start) raises sd_cke[i] for each targeted device and keeps the command pins at NOP.
- R4: Mode 5 (self-refresh) shows an auto-refresh encoding on the targeted chip selects and, in that same cycle, drops their clock enables. Those clock enables then stay low.
- R5: Mode 6 (power-down) drops the targeted clock enables, keeps all chip selects high, and keeps the pins at NOP.
- R6: Mode 0 (normal) raises the clock enable of every targeted device that is in self-refresh or power-down, and returns that device to the awake state.
- R7: While the block is idle, acc_req[i] wakes device i if it is in self-refresh: its clock enable rises and busy is set. acc_req has no effect on a device that is awake or in power-down.
- R8: While any device is in power-down, the block runs a refresh sequence every REF_PERIOD cycles. The first auto-refresh appears REF_PERIOD+1 cycles after the power-down command is accepted. The sequence is three cycles: a NOP cycle with the power-down clock enables high, then an auto-refresh cycle on those devices' chip selects only, then a NOP cycle with those clock enables low again.
- R9: Busy is high for HOLD cycles after a command is accepted, and for three cycles during a refresh sequence. A cmd_valid pulse while busy is high is ignored.
- R10: Mode 7 is reserved and ignored: busy stays low and no pin changes.
- R11: A command with both target bits set acts on both devices in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command request strobe |
| cmd_mode | input | 3 | Mode code, 0 to 7 |
| cmd_target | input | NDEV | Target mask, bit i selects device i |
| acc_req | input | NDEV | Access request per device (wakes from self-refresh) |
| sd_cs_n | output | NDEV | Chip select per device, active low |
| sd_cke | output | NDEV | Clock enable per device |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| busy | output | 1 | Command or low-power transition in progress |

## Verification
The assertions assume that a refresh becoming due and a software command never meet on the same clock edge. They also assume that a command and a wake request are never raised together, so the priority between them is never exercised. The stimulus keeps within these limits. Every command is driven one negative edge after busy is seen low. Each power-down stretch is kept much shorter than REF_PERIOD, or else the bench waits for the expected refresh sequences to be seen before it issues the next command. Access requests are pulsed only while no command is pending.

// File: rtl/sdr_mode_pkg.sv
package sdr_mode_pkg;

  typedef enum logic [2:0] {
    MD_NORMAL    = 3'd0,
    MD_CKE_ON    = 3'd1,
    MD_PRECHARGE = 3'd2,
    MD_AUTOREF   = 3'd3,
    MD_LOADMODE  = 3'd4,
    MD_SELFREF   = 3'd5,
    MD_PWRDOWN   = 3'd6,
    MD_RESERVED  = 3'd7
  } mode_e;

  typedef enum logic [1:0] {
    LP_AWAKE = 2'd0,
    LP_SELF  = 2'd1,
    LP_DOWN  = 2'd2
  } lp_e;

  typedef struct packed {
    logic ras_n;
    logic cas_n;
    logic we_n;
  } pins_t;

  localparam pins_t PINS_NOP = 3'b111;
  localparam pins_t PINS_PRE = 3'b010;
  localparam pins_t PINS_REF = 3'b001;
  localparam pins_t PINS_LMR = 3'b000;

  function automatic pins_t mode_pins(mode_e m);
    case (m)
      MD_PRECHARGE:          return PINS_PRE;
      MD_AUTOREF, MD_SELFREF: return PINS_REF;
      MD_LOADMODE:           return PINS_LMR;
      default:               return PINS_NOP;
    endcase
  endfunction

  function automatic logic mode_selects(mode_e m);
    return (m == MD_PRECHARGE) || (m == MD_AUTOREF) ||
           (m == MD_LOADMODE)  || (m == MD_SELFREF);
  endfunction

endpackage

// File: rtl/sdr_refresh_timer.sv
module sdr_refresh_timer #(
  parameter int REF_PERIOD = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pd_any,
  input  logic idle,
  input  logic ack,
  output logic due
);
  localparam int CW = $clog2(REF_PERIOD + 1);
  localparam logic [CW-1:0] LAST = CW'(REF_PERIOD - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt_q <= '0;
    else if (ack)        cnt_q <= '0;
    else if (!pd_any)    cnt_q <= '0;
    else if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
  end

  assign due = pd_any && idle && (cnt_q == LAST);
endmodule

// File: rtl/sdr_lp_track.sv
module sdr_lp_track
  import sdr_mode_pkg::*;
#(
  parameter int NDEV = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NDEV-1:0] set_sr,
  input  logic [NDEV-1:0] set_pd,
  input  logic [NDEV-1:0] clr,
  output logic [NDEV-1:0] sr_mask,
  output logic [NDEV-1:0] pd_mask
);
  for (genvar i = 0; i < NDEV; i++) begin : g_dev
    lp_e st_q;
    always_ff @(posedge clk) begin
      if (!rst_n)         st_q <= LP_AWAKE;
      else if (set_sr[i]) st_q <= LP_SELF;
      else if (set_pd[i]) st_q <= LP_DOWN;
      else if (clr[i])    st_q <= LP_AWAKE;
    end
    assign sr_mask[i] = (st_q == LP_SELF);
    assign pd_mask[i] = (st_q == LP_DOWN);
  end
endmodule

// File: rtl/sdr_cmd_seq.sv
module sdr_cmd_seq
  import sdr_mode_pkg::*;
#(
  parameter int NDEV = 2,
  parameter int HOLD = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_valid,
  input  logic [2:0]      cmd_mode,
  input  logic [NDEV-1:0] cmd_target,
  input  logic [NDEV-1:0] acc_req,
  input  logic [NDEV-1:0] sr_mask,
  input  logic [NDEV-1:0] pd_mask,
  input  logic            ref_due,
  output logic            idle,
  output logic            accept,
  output logic            wake,
  output logic            rf_start,
  output logic            rf_cmd_phase,
  output logic [NDEV-1:0] set_sr,
  output logic [NDEV-1:0] set_pd,
  output logic [NDEV-1:0] clr,
  output logic [NDEV-1:0] cs_n,
  output logic [NDEV-1:0] cke,
  output pins_t           pins,
  output logic            busy
);
  localparam int HW = $clog2(HOLD + 1);

  typedef enum logic [2:0] {S_IDLE, S_HOLD, S_RF_UP, S_RF_CMD, S_RF_DN} st_e;

  st_e             st_q;
  logic [HW-1:0]   cnt_q;
  logic [NDEV-1:0] cs_q, cke_q, rf_mask_q, wake_mask, cke_cmd;
  pins_t           pins_q;
  mode_e           m;

  assign m         = mode_e'(cmd_mode);
  assign idle      = (st_q == S_IDLE);
  assign rf_start  = idle && ref_due;
  assign accept    = idle && !ref_due && cmd_valid && (m != MD_RESERVED);
  assign wake_mask = acc_req & sr_mask;
  assign wake      = idle && !ref_due && !accept && (|wake_mask);
  assign rf_cmd_phase = (st_q == S_RF_CMD);

  always_comb begin
    cke_cmd = cke_q;
    case (m)
      MD_CKE_ON:              cke_cmd = cke_q | cmd_target;
      MD_SELFREF, MD_PWRDOWN: cke_cmd = cke_q & ~cmd_target;
      MD_NORMAL:              cke_cmd = cke_q | (cmd_target & (sr_mask | pd_mask));
      default:                cke_cmd = cke_q;
    endcase
  end

  always_comb begin
    set_sr = '0;
    set_pd = '0;
    clr    = '0;
    if (accept && m == MD_SELFREF) set_sr = cmd_target;
    if (accept && m == MD_PWRDOWN) set_pd = cmd_target;
    if (accept && m == MD_NORMAL)  clr    = cmd_target & (sr_mask | pd_mask);
    if (wake)                      clr    = wake_mask;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q      <= S_IDLE;
      cnt_q     <= '0;
      cs_q      <= '1;
      cke_q     <= '0;
      rf_mask_q <= '0;
      pins_q    <= PINS_NOP;
    end else begin
      case (st_q)
        S_IDLE: begin
          cs_q   <= '1;
          pins_q <= PINS_NOP;
          if (rf_start) begin
            st_q      <= S_RF_UP;
            rf_mask_q <= pd_mask;
            cke_q     <= cke_q | pd_mask;
          end else if (accept) begin
            st_q   <= S_HOLD;
            cnt_q  <= HW'(HOLD - 1);
            pins_q <= mode_pins(m);
            if (mode_selects(m)) cs_q <= ~cmd_target;
            cke_q  <= cke_cmd;
          end else if (wake) begin
            st_q  <= S_HOLD;
            cnt_q <= HW'(HOLD - 1);
            cke_q <= cke_q | wake_mask;
          end
        end
        S_HOLD: begin
          cs_q   <= '1;
          pins_q <= PINS_NOP;
          if (cnt_q == '0) st_q <= S_IDLE;
          else             cnt_q <= cnt_q - 1'b1;
        end
        S_RF_UP: begin
          cs_q   <= ~rf_mask_q;
          pins_q <= PINS_REF;
          st_q   <= S_RF_CMD;
        end
        S_RF_CMD: begin
          cs_q   <= '1;
          pins_q <= PINS_NOP;
          cke_q  <= cke_q & ~rf_mask_q;
          st_q   <= S_RF_DN;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign cs_n = cs_q;
  assign cke  = cke_q;
  assign pins = pins_q;
  assign busy = !idle;
endmodule

// File: rtl/sdr_mode_ctrl.sv
module sdr_mode_ctrl
  import sdr_mode_pkg::*;
#(
  parameter int NDEV       = 2,
  parameter int HOLD       = 3,
  parameter int REF_PERIOD = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_valid,
  input  logic [2:0]      cmd_mode,
  input  logic [NDEV-1:0] cmd_target,
  input  logic [NDEV-1:0] acc_req,
  output logic [NDEV-1:0] sd_cs_n,
  output logic [NDEV-1:0] sd_cke,
  output logic            sd_ras_n,
  output logic            sd_cas_n,
  output logic            sd_we_n,
  output logic            busy
);
  logic [NDEV-1:0] sr_mask, pd_mask, set_sr, set_pd, clr;
  logic idle, accept, wake, rf_start, rf_cmd_phase, ref_due;
  pins_t pins;

  sdr_lp_track #(.NDEV(NDEV)) u_track (
    .clk(clk), .rst_n(rst_n), .set_sr(set_sr), .set_pd(set_pd), .clr(clr),
    .sr_mask(sr_mask), .pd_mask(pd_mask)
  );

  sdr_refresh_timer #(.REF_PERIOD(REF_PERIOD)) u_timer (
    .clk(clk), .rst_n(rst_n), .pd_any(|pd_mask), .idle(idle),
    .ack(rf_start), .due(ref_due)
  );

  sdr_cmd_seq #(.NDEV(NDEV), .HOLD(HOLD)) u_seq (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_mode(cmd_mode),
    .cmd_target(cmd_target), .acc_req(acc_req), .sr_mask(sr_mask),
    .pd_mask(pd_mask), .ref_due(ref_due), .idle(idle), .accept(accept),
    .wake(wake), .rf_start(rf_start), .rf_cmd_phase(rf_cmd_phase),
    .set_sr(set_sr), .set_pd(set_pd), .clr(clr), .cs_n(sd_cs_n),
    .cke(sd_cke), .pins(pins), .busy(busy)
  );

  assign sd_ras_n = pins.ras_n;
  assign sd_cas_n = pins.cas_n;
  assign sd_we_n  = pins.we_n;
endmodule

// File: rtl/sdr_mode_ctrl_chk.sv
module sdr_mode_ctrl_chk #(
  parameter int NDEV = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cmd_valid,
  input logic [2:0]      cmd_mode,
  input logic [NDEV-1:0] acc_req,
  input logic [NDEV-1:0] sd_cs_n,
  input logic [NDEV-1:0] sd_cke,
  input logic            sd_ras_n,
  input logic            sd_cas_n,
  input logic            sd_we_n,
  input logic            busy,
  input logic [NDEV-1:0] sr_mask,
  input logic [NDEV-1:0] pd_mask,
  input logic            ref_due,
  input logic            rf_cmd_phase
);
  AST_CS_ONLY_ON_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
    (sd_cs_n != '1) |-> ($rose(busy) || rf_cmd_phase)); // R9

  AST_IDLE_CKE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && $past(!busy)) |-> $stable(sd_cke)); // R9

  AST_SELF_CKE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> ((sd_cke & sr_mask) == '0)); // R4

  AST_DOWN_CKE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> ((sd_cke & pd_mask) == '0)); // R5

  AST_REF_ONLY_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    rf_cmd_phase |-> (((~sd_cs_n) & ~pd_mask) == '0 && !sd_ras_n && !sd_cas_n && sd_we_n)); // R8

  AST_REF_CKE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    rf_cmd_phase |-> ((sd_cke & pd_mask) == pd_mask)); // R8

  AST_RESERVED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_mode == 3'd7 && !busy && !ref_due && (acc_req & sr_mask) == '0)
      |=> !busy); // R10
endmodule

bind sdr_mode_ctrl sdr_mode_ctrl_chk #(.NDEV(NDEV)) chk_i (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_mode(cmd_mode),
  .acc_req(acc_req), .sd_cs_n(sd_cs_n), .sd_cke(sd_cke), .sd_ras_n(sd_ras_n),
  .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n), .busy(busy), .sr_mask(sr_mask),
  .pd_mask(pd_mask), .ref_due(ref_due), .rf_cmd_phase(rf_cmd_phase)
);

// File: tb/sdr_mode_ctrl_tb_top.sv
module sdr_mode_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int HOLD = 3;
  localparam int REF_PERIOD = 16;
  localparam int LIMIT = 20000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [2:0] cmd_mode = 3'd0;
  logic [1:0] cmd_target = 2'b00;
  logic [1:0] acc_req = 2'b00;
  logic [1:0] sd_cs_n, sd_cke;
  logic sd_ras_n, sd_cas_n, sd_we_n, busy;

  sdr_mode_ctrl #(.NDEV(2), .HOLD(HOLD), .REF_PERIOD(REF_PERIOD)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_mode(cmd_mode),
    .cmd_target(cmd_target), .acc_req(acc_req), .sd_cs_n(sd_cs_n),
    .sd_cke(sd_cke), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n),
    .sd_we_n(sd_we_n), .busy(busy)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  logic [6:0] exp_q[$];
  string tag_q[$];
  string cur_tag = "R1";
  logic [1:0] prev_cke = 2'b00;
  bit ref_watch = 1'b0;
  int ref_t[$];
  logic [1:0] cke_m = 2'b00, sr_m = 2'b00, pd_m = 2'b00;
  bit done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // monitor: every cycle with an active chip select or a clock-enable change is an event
  always @(negedge clk) begin
    if (rst_n) begin
      if (sd_cs_n != 2'b11 || sd_cke != prev_cke) begin
        logic [6:0] ev;
        ev = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_cke};
        if (ref_watch && sd_cs_n != 2'b11 && {sd_ras_n, sd_cas_n, sd_we_n} == 3'b001)
          ref_t.push_back(cyc);
        if (exp_q.size() == 0) check(1'b0, {cur_tag, " unexpected event"}, 32'(ev), 32'h0);
        else begin
          logic [6:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(ev == e, t, 32'(ev), 32'(e));
        end
      end
      prev_cke = sd_cke;
    end else prev_cke = 2'b00;
  end

  task automatic push_ev(input logic [1:0] cs, input logic [2:0] p, input logic [1:0] ck, input string tag);
    exp_q.push_back({cs, p, ck});
    tag_q.push_back(tag);
  endtask

  task automatic model(input logic [2:0] md, input logic [1:0] tg, input string tag);
    logic [1:0] cs, nck;
    logic [2:0] p;
    cs = 2'b11; p = 3'b111; nck = cke_m;
    case (md)
      3'd0: begin nck = cke_m | (tg & (sr_m | pd_m)); sr_m &= ~tg; pd_m &= ~tg; end
      3'd1: nck = cke_m | tg;
      3'd2: begin cs = ~tg; p = 3'b010; end
      3'd3: begin cs = ~tg; p = 3'b001; end
      3'd4: begin cs = ~tg; p = 3'b000; end
      3'd5: begin cs = ~tg; p = 3'b001; nck = cke_m & ~tg; sr_m |= tg; end
      3'd6: begin nck = cke_m & ~tg; pd_m |= tg; end
      default: ;
    endcase
    if (cs != 2'b11 || nck != cke_m) push_ev(cs, p, nck, tag);
    cke_m = nck;
  endtask

  // returns the cycle number of the accepting edge
  task automatic issue(input logic [2:0] md, input logic [1:0] tg, input string tag, output int acc);
    @(negedge clk);
    while (busy) @(negedge clk);
    cur_tag = tag;
    model(md, tg, tag);
    cmd_valid = 1'b1; cmd_mode = md; cmd_target = tg;
    @(negedge clk);
    acc = cyc;
    cmd_valid = 1'b0;
  endtask

  task automatic drain(input string tag);
    int g = 0;
    while ((exp_q.size() != 0 || busy) && g < 400) begin @(negedge clk); g++; end
    check(exp_q.size() == 0, {tag, " expected events seen"}, 32'(exp_q.size()), 32'h0);
  endtask

  initial begin
    repeat (LIMIT) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", LIMIT, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    int a, bc;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(sd_cke == 2'b00, "R1 cke", 32'(sd_cke), 0);
    check(sd_cs_n == 2'b11, "R1 cs_n", 32'(sd_cs_n), 3);
    check({sd_ras_n, sd_cas_n, sd_we_n} == 3'b111, "R1 pins", 32'({sd_ras_n, sd_cas_n, sd_we_n}), 7);
    check(busy == 1'b0, "R1 busy", 32'(busy), 0);
    rst_n = 1'b1;

    // R3 + R11 clock enable start on both, R9 busy length
    issue(3'd1, 2'b11, "R3", a);
    bc = 0;
    while (busy && bc < 50) begin bc++; @(negedge clk); end
    check(bc == HOLD, "R9 busy cycles", 32'(bc), 32'(HOLD));
    drain("R3");

    // R2 encodings
    issue(3'd2, 2'b01, "R2 precharge", a); drain("R2");
    issue(3'd3, 2'b10, "R2 autorefresh", a); drain("R2");
    issue(3'd4, 2'b11, "R11 loadmode both", a); drain("R11");

    // R9 command while busy ignored
    issue(3'd2, 2'b10, "R9", a);
    check(busy == 1'b1, "R9 busy after accept", 32'(busy), 1);
    cmd_valid = 1'b1; cmd_mode = 3'd4; cmd_target = 2'b11;
    @(negedge clk); cmd_valid = 1'b0;
    repeat (6) @(negedge clk);
    drain("R9");

    // R10 reserved
    cur_tag = "R10";
    cmd_valid = 1'b1; cmd_mode = 3'd7; cmd_target = 2'b11;
    @(negedge clk); cmd_valid = 1'b0;
    check(busy == 1'b0, "R10 busy stays low", 32'(busy), 0);
    repeat (3) @(negedge clk);

    // R4 self-refresh on device 1, R7 wake rules
    issue(3'd5, 2'b10, "R4", a); drain("R4");
    cur_tag = "R7 awake device";
    acc_req = 2'b01; @(negedge clk); acc_req = 2'b00;
    check(busy == 1'b0, "R7 no wake for awake device", 32'(busy), 0);
    repeat (3) @(negedge clk);
    cur_tag = "R7";
    push_ev(2'b11, 3'b111, 2'b11, "R7 wake from self-refresh");
    cke_m = 2'b11; sr_m = 2'b00;
    acc_req = 2'b10; @(negedge clk); acc_req = 2'b00;
    check(busy == 1'b1, "R7 busy on wake", 32'(busy), 1);
    drain("R7");

    // R5 power-down, access request ignored, R6 exit
    issue(3'd6, 2'b10, "R5", a); drain("R5");
    cur_tag = "R7 power-down";
    acc_req = 2'b10; @(negedge clk); acc_req = 2'b00;
    check(busy == 1'b0 && sd_cke == 2'b01, "R7 power-down not woken", 32'({busy, sd_cke}), 32'(1));
    issue(3'd0, 2'b10, "R6 exit power-down", a); drain("R6");

    // R8 refresh in power-down, device 0 in self-refresh
    issue(3'd5, 2'b01, "R4 device0", a); drain("R4");
    ref_watch = 1'b1;
    issue(3'd6, 2'b10, "R5 device1", a);
    for (int k = 0; k < 3; k++) begin
      push_ev(2'b11, 3'b111, 2'b10, "R8 cke up");
      push_ev(2'b01, 3'b001, 2'b10, "R8 refresh");
      push_ev(2'b11, 3'b111, 2'b00, "R8 cke down");
    end
    begin
      int g = 0;
      while (exp_q.size() != 0 && g < 400) begin @(negedge clk); g++; end
    end
    check(exp_q.size() == 0, "R8 three refresh sequences", 32'(exp_q.size()), 0);
    ref_watch = 1'b0;
    check(ref_t.size() == 3, "R8 refresh count", 32'(ref_t.size()), 3);
    if (ref_t.size() == 3) begin
      check(ref_t[0] - a == REF_PERIOD + 1, "R8 first refresh delay", 32'(ref_t[0] - a), 32'(REF_PERIOD + 1));
      check(ref_t[1] - ref_t[0] == REF_PERIOD, "R8 period", 32'(ref_t[1] - ref_t[0]), 32'(REF_PERIOD));
      check(ref_t[2] - ref_t[1] == REF_PERIOD, "R8 period", 32'(ref_t[2] - ref_t[1]), 32'(REF_PERIOD));
    end
    issue(3'd0, 2'b11, "R6 R11 exit both", a); drain("R6");
    check(sd_cke == 2'b11, "R6 both awake", 32'(sd_cke), 3);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule